// File: doc/BRIEF.md
# Non-Stalling Diagnostic Byte FIFO

This block is a byte-wide first-in first-out store that a host exercises directly in a diagnostic mode. The host pushes bytes with a write strobe and pops them with a read strobe, in either transfer direction. No handshake with the peripheral lines is involved. The FIFO never holds the host off. A push into a full store is thrown away and leaves the stored bytes intact. A pop from an empty store hands back the byte that was popped last. The full and empty flags follow the true occupancy at all times.

A service-interrupt level tells software when a batch of work is worth doing. In the outbound direction it reports that enough free space has opened up. In the inbound direction it reports that enough bytes are waiting. Both thresholds are programmable. A clear pulse silences the level until its condition has first gone away and then come back. Software can find the depth and the thresholds by filling or draining the store one byte at a time and watching the full flag and the service level.

Top module: `lbf_top`

## Requirements
- R1: Accepted bytes come out in the order they were written, and a popped byte appears on `rd_data` in the cycle after the read strobe.
- R2: `full` is 1 exactly when DEPTH (default 16) bytes are held, and `empty` is 1 exactly when none are held. Both flags are combinational from the registered occupancy and change in the cycle after the strobe.
- R3: A write strobe while `full` is 1 is discarded, and the stored bytes and their order stay unchanged.
- R4: A read strobe while `empty` is 1 leaves `rd_data` at the last popped byte. After reset this byte is 0x00.
- R5: After discarded writes and repeated reads, `full` and `empty` still match the number of bytes actually held.
- R6: With `dir` = 0, `svc_irq` is 1 when the free space (DEPTH minus occupancy) is at least `wr_thresh`. It follows the occupancy with one extra cycle of latency.
- R7: With `dir` = 1, `svc_irq` is 1 when the occupancy is at least `rd_thresh`, with the same latency.
- R8: A `svc_clr` pulse drives `svc_irq` to 0 on the next cycle. The level then stays 0 until its condition has been false for at least one cycle and has become true again.
- R9: When reads and writes come in the same cycle, three cases apply. On a FIFO that is neither empty nor full, both take effect and the occupancy is unchanged. On a full FIFO, only the read takes effect. On an empty FIFO, only the write takes effect and the read repeats the last byte.
- R10: After reset, `empty` = 1, `full` = 0 and `rd_data` = 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Host read strobe, one byte per cycle |
| rd_data | output | 8 | Last popped byte |
| dir | input | 1 | Transfer direction: 0 outbound, 1 inbound |
| wr_thresh | input | 5 | Free-space threshold used when dir = 0 |
| rd_thresh | input | 5 | Occupancy threshold used when dir = 1 |
| svc_clr | input | 1 | Pulse that clears the service level |
| full | output | 1 | Store holds DEPTH bytes |
| empty | output | 1 | Store holds no bytes |
| svc_irq | output | 1 | Registered service-interrupt level |

## Verification
The read and write strobes can land in the same cycle. The bench provokes this with both strobes high in three occupancy states: partly filled, full and empty. In the partly filled case it judges the result by the popped byte, by the unchanged flags, and by draining the store to confirm the order and the count. The bench also raises the clear pulse while the service condition still holds. It checks that the level stays low until the occupancy has left the condition and come back into it.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
  typedef enum logic {
    LBF_OUTBOUND = 1'b0,
    LBF_INBOUND  = 1'b1
  } lbf_dir_e;
endpackage

// File: rtl/lbf_ctrl.sv
module lbf_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);

  logic [AW-1:0] wptr_d, rptr_d;
  logic [CW-1:0] count_d;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);
  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;

  always_comb begin
    wptr_d  = wptr;
    rptr_d  = rptr;
    count_d = count;
    if (wr_ok) wptr_d = (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
    if (rd_ok) rptr_d = (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
    case ({wr_ok, rd_ok})
      2'b10:   count_d = count + 1'b1;
      2'b01:   count_d = count - 1'b1;
      default: count_d = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= wptr_d;
      if (rd_ok) rptr <= rptr_d;
      if (wr_ok ^ rd_ok) count <= count_d;
    end
  end

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (full && $stable(count) && $stable(wptr)));

  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= DEPTH_C));

  p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && wr_en && !rd_en) |=> !empty);

  p_simul_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && !empty && wr_en && rd_en) |=> $stable(count));
endmodule

// File: rtl/lbf_store.sv
module lbf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic          rd_ok,
  input  logic [AW-1:0] wptr,
  input  logic [AW-1:0] rptr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] last_q
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] last_d;

  always_comb begin
    last_d = last_q;
    if (rd_ok) last_d = mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else if (rd_ok) last_q <= last_d;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(last_q));
endmodule

// File: rtl/lbf_svc.sv
module lbf_svc
  import lbf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  lbf_dir_e      dir,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] wr_thresh,
  input  logic [CW-1:0] rd_thresh,
  input  logic          clr,
  output logic          irq
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] space;
  logic          cond;
  logic          armed_q, armed_d, irq_d;

  assign space = DEPTH_C - count;

  always_comb begin
    if (dir == LBF_INBOUND) cond = (count >= rd_thresh);
    else                    cond = (space >= wr_thresh);

    armed_d = armed_q;
    if (clr)        armed_d = 1'b0;
    else if (!cond) armed_d = 1'b1;

    irq_d = cond & armed_q & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq     <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq     <= irq_d;
    end
  end

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq);

  p_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && cond && !clr) |=> !irq);
endmodule

// File: rtl/lbf_top.sv
module lbf_top
  import lbf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          dir,
  input  logic [CW-1:0] wr_thresh,
  input  logic [CW-1:0] rd_thresh,
  input  logic          svc_clr,
  output logic          full,
  output logic          empty,
  output logic          svc_irq
);
  logic [1:0]    rst_sync;
  logic          rst_ns;
  logic          wr_ok, rd_ok;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  lbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .rd_en(rd_en),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr),
    .count(count), .full(full), .empty(empty)
  );

  lbf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_ns), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .wptr(wptr), .rptr(rptr), .wr_data(wr_data), .last_q(rd_data)
  );

  lbf_svc #(.DEPTH(DEPTH)) u_svc (
    .clk(clk), .rst_n(rst_ns), .dir(lbf_dir_e'(dir)), .count(count),
    .wr_thresh(wr_thresh), .rd_thresh(rd_thresh), .clr(svc_clr),
    .irq(svc_irq)
  );

  p_empty_repeat_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (empty && rd_en) |=> $stable(rd_data));

  p_flags_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    !(full && empty));

  p_full_read_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    (full && rd_en) |=> !full);
endmodule

// File: tb/sim_lbf_top.sv
`timescale 1ns/1ps
module sim_lbf_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, dir = 1'b0, svc_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [4:0] wr_thresh = 5'd4, rd_thresh = 5'd5;
  logic [7:0] rd_data;
  logic       full, empty, svc_irq;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] mq[$];
  logic [7:0] ml = 8'h00;

  always #2 clk = ~clk;

  lbf_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dir(dir), .wr_thresh(wr_thresh),
    .rd_thresh(rd_thresh), .svc_clr(svc_clr), .full(full),
    .empty(empty), .svc_irq(svc_irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // one cycle of strobes; model update and flag/data checks
  task automatic op(bit w, logic [7:0] d, bit r, string req);
    bit wok, rok;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r;
    wok = w && (mq.size() < DEPTH);
    rok = r && (mq.size() > 0);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (rok) ml = mq.pop_front();
    if (wok) mq.push_back(d);
    chk(req, "rd_data", rd_data, ml);
    chk(req, "empty", empty, mq.size() == 0);
    chk(req, "full", full, mq.size() == DEPTH);
  endtask

  task automatic t_reset();
    chk("R10", "empty", empty, 1);
    chk("R10", "full", full, 0);
    chk("R10", "rd_data", rd_data, 8'h00);
  endtask

  task automatic t_empty_read_after_reset();
    op(0, 8'h00, 1, "R4");
    chk("R4", "reset last byte", rd_data, 8'h00);
  endtask

  task automatic t_fill_overflow_drain();
    for (int i = 0; i < DEPTH; i++) op(1, 8'h10 + 8'(i), 0, "R2");
    chk("R2", "full at depth", full, 1);
    op(1, 8'hEE, 0, "R3");
    op(1, 8'hEF, 0, "R3");
    for (int i = 0; i < DEPTH; i++) begin
      op(0, 8'h00, 1, "R1");
      chk("R1", "order", rd_data, 8'h10 + 8'(i));
    end
    chk("R5", "empty after drain", empty, 1);
  endtask

  task automatic t_underflow_repeat();
    op(0, 8'h00, 1, "R4");
    chk("R4", "repeat", rd_data, 8'h1F);
    op(0, 8'h00, 1, "R4");
    op(1, 8'h5A, 0, "R5");
    chk("R5", "not empty", empty, 0);
    op(0, 8'h00, 1, "R5");
    chk("R5", "empty again", empty, 1);
  endtask

  task automatic t_simultaneous();
    op(1, 8'hA1, 0, "R9"); op(1, 8'hA2, 0, "R9"); op(1, 8'hA3, 0, "R9");
    op(1, 8'hA4, 1, "R9");
    chk("R9", "mid read", rd_data, 8'hA1);
    for (int i = 0; i < 3; i++) op(0, 8'h00, 1, "R9");
    chk("R9", "last of three", rd_data, 8'hA4);
    chk("R9", "count unchanged", empty, 1);
    op(1, 8'hB7, 1, "R9");
    chk("R9", "empty case repeat", rd_data, 8'hA4);
    chk("R9", "empty case write", empty, 0);
    for (int i = 1; i < DEPTH; i++) op(1, 8'hC0 + 8'(i), 0, "R9");
    op(1, 8'hDD, 1, "R9");
    chk("R9", "full case read", rd_data, 8'hB7);
    chk("R9", "full case drop", full, 0);
    while (mq.size() > 0) op(0, 8'h00, 1, "R9");
    chk("R9", "no dropped byte", rd_data, 8'hCF);
  endtask

  task automatic t_svc_out();
    dir = 1'b0; wr_thresh = 5'd4;
    idle(2);
    chk("R6", "svc empty", svc_irq, 1);
    for (int i = 0; i < 13; i++) op(1, 8'(i), 0, "R6");
    idle(2);
    chk("R6", "svc free 3", svc_irq, 0);
    op(0, 8'h00, 1, "R6");
    idle(2);
    chk("R6", "svc free 4", svc_irq, 1);
    while (mq.size() > 0) op(0, 8'h00, 1, "R6");
  endtask

  task automatic t_svc_in();
    dir = 1'b1; rd_thresh = 5'd5;
    for (int i = 0; i < 4; i++) op(1, 8'h40 + 8'(i), 0, "R7");
    idle(2);
    chk("R7", "svc occ 4", svc_irq, 0);
    op(1, 8'h44, 0, "R7");
    idle(2);
    chk("R7", "svc occ 5", svc_irq, 1);
  endtask

  task automatic t_svc_clear();
    @(negedge clk); svc_clr = 1'b1;
    @(negedge clk); svc_clr = 1'b0;
    chk("R8", "after clear", svc_irq, 0);
    idle(3);
    chk("R8", "held low", svc_irq, 0);
    op(0, 8'h00, 1, "R8");
    idle(2);
    chk("R8", "cond false", svc_irq, 0);
    op(1, 8'h45, 0, "R8");
    idle(2);
    chk("R8", "re-armed", svc_irq, 1);
    while (mq.size() > 0) op(0, 8'h00, 1, "R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual still running, expected done");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_empty_read_after_reset();
    t_fill_overflow_drain();
    t_underflow_repeat();
    t_simultaneous();
    t_svc_out();
    t_svc_in();
    t_svc_clear();
    summary();
  end
endmodule